// File: doc/BRIEF.md
# Queued Serial Transfer Engine

This block is a serial-peripheral master that works through a stored list of transfers without any help from the processor. Each list slot pairs a transmit word with a command word. The command word chooses which peripheral is addressed, how many bits are moved and whether the select stays active after the word. For every slot that runs, the word shifted in from the peripheral is written to a receive slot with the same index.

Software fills the transmit and command memories through a simple write port and sets the first and last slot, the clock divider and the wrap option. It then raises the enable input. The engine runs every slot from the first to the last, wrapping past slot 31 to slot 0 if it has to. On each word it drives the serial clock and data out, samples data in, and presents a 4-bit select code for an external decoder.

When the last slot has finished, the engine raises a done flag and stops. In wrap mode it instead starts again from the first slot, so a serial converter is read over and over without further action. Dropping enable stops the engine once the current word is finished.

Top module: `qspi_engine`

## Requirements
- R1: After reset, `sck` and `mosi` are 0, `pcs` is 4'hF (the idle code), and `busy` and `done` are 0.
- R2: A rising edge on `cfg_enable` while idle starts a run at slot `cfg_start`. Slots are executed in increasing index order up to and including `cfg_end`. Each word is shifted out on `mosi` most significant bit first, starting from bit (length-1) of the transmit word.
- R3: `miso` is sampled on each rising `sck` edge. The received word is right-aligned with its upper bits zero, and is written to the receive slot whose index equals the command slot. It can then be read at `rd_data` for `rd_addr`.
- R4: The `sck` period inside a word is 2×N system clocks, where N is `cfg_div`. Any value of `cfg_div` below 2 acts as 2.
- R5: Command bits [8:5] hold a length code c. The word length is c+1 bits, with a floor of 8, so every code below 7 gives 8 bits.
- R6: Command bits [3:0] form the select code, and `pcs` carries it whenever `sck` is high. With command bit 4 clear, `pcs` returns to 4'hF for one cycle before the next word. With bit 4 set, `pcs` keeps its code until the next word's code is driven. `pcs` is 4'hF whenever the engine is idle.
- R7: When the slot at `cfg_end` finishes with wrap off, `done` rises and `busy` falls. `done` stays high until the next run starts.
- R8: With `cfg_wrap` set, the engine goes back to `cfg_start` after `cfg_end` and keeps running. `done` is set after the first pass and stays set.
- R9: Clearing `cfg_enable` during a word lets that word finish with all its bits. The engine then halts, and `done` stays low if the halted slot was not `cfg_end`.
- R10: Slot indices advance modulo 32, so a run whose first slot is above its last slot continues from slot 31 to slot 0.
- R11: `sck` idles low, and `mosi` changes only while `sck` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the list memories |
| wr_cmd | input | 1 | 1 writes the command memory, 0 the transmit memory |
| wr_addr | input | 5 | Slot index written |
| wr_data | input | 16 | Write data (command uses bits [8:0]) |
| rd_addr | input | 5 | Receive slot index read |
| rd_data | output | 16 | Receive slot contents |
| cfg_enable | input | 1 | Run enable; a rising edge starts a run |
| cfg_wrap | input | 1 | Restart from the first slot after the last |
| cfg_start | input | 5 | First slot of the run |
| cfg_end | input | 5 | Last slot of the run |
| cfg_div | input | 8 | Half-period of the serial clock in system clocks |
| miso | input | 1 | Serial data from the peripheral |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| pcs | output | 4 | Encoded peripheral select |
| busy | output | 1 | Engine is running a list |
| done | output | 1 | Last slot of the run has completed |

## Verification
The properties assume that software does not change the configuration inputs or write the list memories while `busy` is high, and that `cfg_enable` is low while `rst` is high. Every bench scenario sets up the memories and the configuration while the engine is idle and holds them until `busy` falls. The bench only ever clears `cfg_enable` mid-run, which is the one change the design is meant to tolerate. The bench's model of the peripheral changes `miso` only on falling `sck` edges, so the sampled bit is steady for a full half-period before each rising edge.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    localparam int SEL_W = 4;
    localparam logic [SEL_W-1:0] SEL_IDLE = '1;

    // Command word layout: [8:5] length code, [4] keep select, [3:0] select code
    typedef struct packed {
        logic [3:0]       len_code;
        logic             hold;
        logic [SEL_W-1:0] sel;
    } qspi_cmd_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LO,
        SH_HI
    } shift_state_e;

    typedef enum logic [1:0] {
        Q_IDLE,
        Q_LAUNCH,
        Q_WAIT
    } queue_state_e;

    // Word length from the length code: code + 1, never below 8
    function automatic logic [4:0] word_len(input logic [3:0] code);
        if (code < 4'd7) return 5'd8;
        return {1'b0, code} + 5'd1;
    endfunction

endpackage

// File: rtl/qspi_ram.sv
module qspi_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter
    import qspi_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    parameter int BITS_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIV_W-1:0]  div,
    input  logic [BITS_W-1:0] nbits,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              fin,
    output logic [DATA_W-1:0] rx_word
);
    shift_state_e      st;
    logic [DIV_W-1:0]  cnt;
    logic [DIV_W-1:0]  half;
    logic [BITS_W-1:0] left;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;

    // Half-period with the floor of two system clocks
    assign half = (div < DIV_W'(2)) ? DIV_W'(2) : div;
    assign mosi = tx_sh[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SH_IDLE;
            sck     <= 1'b0;
            fin     <= 1'b0;
            cnt     <= '0;
            left    <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_word <= '0;
        end else begin
            fin <= 1'b0;
            case (st)
                SH_IDLE: begin
                    if (start) begin
                        // Left-align the word so its top bit sits on mosi
                        tx_sh <= tx_word << (BITS_W'(DATA_W) - nbits);
                        rx_sh <= '0;
                        cnt   <= half - DIV_W'(1);
                        left  <= nbits - BITS_W'(1);
                        st    <= SH_LO;
                    end
                end
                SH_LO: begin
                    if (cnt == '0) begin
                        sck   <= 1'b1;
                        rx_sh <= {rx_sh[DATA_W-2:0], miso};
                        cnt   <= half - DIV_W'(1);
                        st    <= SH_HI;
                    end else begin
                        cnt <= cnt - DIV_W'(1);
                    end
                end
                SH_HI: begin
                    if (cnt == '0) begin
                        sck <= 1'b0;
                        if (left == '0) begin
                            fin     <= 1'b1;
                            rx_word <= rx_sh;
                            st      <= SH_IDLE;
                        end else begin
                            tx_sh <= tx_sh << 1;
                            left  <= left - BITS_W'(1);
                            cnt   <= half - DIV_W'(1);
                            st    <= SH_LO;
                        end
                    end else begin
                        cnt <= cnt - DIV_W'(1);
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/qspi_sequencer.sv
module qspi_sequencer
    import qspi_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             wrap,
    input  logic [PTR_W-1:0] start_ptr,
    input  logic [PTR_W-1:0] end_ptr,
    input  qspi_cmd_t        cmd,
    input  logic             fin,
    output logic [PTR_W-1:0] ptr,
    output logic             launch,
    output logic [SEL_W-1:0] pcs,
    output logic             busy,
    output logic             done,
    output logic             rx_we
);
    queue_state_e     st;
    logic             en_q;
    logic             at_end;
    logic [PTR_W-1:0] next_ptr;

    assign launch   = (st == Q_LAUNCH);
    assign busy     = (st != Q_IDLE);
    assign rx_we    = (st == Q_WAIT) && fin;
    assign at_end   = (ptr == end_ptr);
    assign next_ptr = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + PTR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= Q_IDLE;
            en_q <= 1'b0;
            ptr  <= '0;
            pcs  <= SEL_IDLE;
            done <= 1'b0;
        end else begin
            en_q <= enable;
            case (st)
                Q_IDLE: begin
                    pcs <= SEL_IDLE;
                    if (enable && !en_q) begin
                        ptr  <= start_ptr;
                        done <= 1'b0;
                        st   <= Q_LAUNCH;
                    end
                end
                Q_LAUNCH: begin
                    pcs <= cmd.sel;
                    st  <= Q_WAIT;
                end
                Q_WAIT: begin
                    if (fin) begin
                        if (at_end) done <= 1'b1;
                        if (!enable || (at_end && !wrap)) begin
                            pcs <= SEL_IDLE;
                            st  <= Q_IDLE;
                        end else begin
                            ptr <= at_end ? start_ptr : next_ptr;
                            if (!cmd.hold) pcs <= SEL_IDLE;
                            st  <= Q_LAUNCH;
                        end
                    end
                end
                default: st <= Q_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/qspi_engine.sv
module qspi_engine
    import qspi_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    parameter int DIV_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     wr_cmd,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     cfg_enable,
    input  logic                     cfg_wrap,
    input  logic [$clog2(DEPTH)-1:0] cfg_start,
    input  logic [$clog2(DEPTH)-1:0] cfg_end,
    input  logic [DIV_W-1:0]         cfg_div,
    input  logic                     miso,
    output logic                     sck,
    output logic                     mosi,
    output logic [3:0]               pcs,
    output logic                     busy,
    output logic                     done
);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int CMD_W  = $bits(qspi_cmd_t);
    localparam int BITS_W = $clog2(DATA_W + 1);

    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] tx_word;
    logic [CMD_W-1:0]  cmd_raw;
    qspi_cmd_t         cmd;
    logic [DATA_W-1:0] rx_word;
    logic              launch;
    logic              fin;
    logic              rx_we;
    logic [BITS_W-1:0] nbits;

    assign cmd   = qspi_cmd_t'(cmd_raw);
    assign nbits = BITS_W'(word_len(cmd.len_code));

    qspi_ram #(.W(DATA_W), .DEPTH(DEPTH)) tx_mem_i (
        .clk(clk), .we(wr_en && !wr_cmd), .waddr(wr_addr), .wdata(wr_data),
        .raddr(ptr), .rdata(tx_word)
    );

    qspi_ram #(.W(CMD_W), .DEPTH(DEPTH)) cmd_mem_i (
        .clk(clk), .we(wr_en && wr_cmd), .waddr(wr_addr), .wdata(wr_data[CMD_W-1:0]),
        .raddr(ptr), .rdata(cmd_raw)
    );

    qspi_ram #(.W(DATA_W), .DEPTH(DEPTH)) rx_mem_i (
        .clk(clk), .we(rx_we), .waddr(ptr), .wdata(rx_word),
        .raddr(rd_addr), .rdata(rd_data)
    );

    qspi_sequencer #(.DEPTH(DEPTH), .PTR_W(PTR_W)) seq_i (
        .clk(clk), .rst(rst), .enable(cfg_enable), .wrap(cfg_wrap),
        .start_ptr(cfg_start), .end_ptr(cfg_end), .cmd(cmd), .fin(fin),
        .ptr(ptr), .launch(launch), .pcs(pcs), .busy(busy), .done(done),
        .rx_we(rx_we)
    );

    qspi_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W), .BITS_W(BITS_W)) shift_i (
        .clk(clk), .rst(rst), .start(launch), .div(cfg_div), .nbits(nbits),
        .tx_word(tx_word), .miso(miso), .sck(sck), .mosi(mosi), .fin(fin),
        .rx_word(rx_word)
    );
endmodule

// File: rtl/qspi_engine_chk.sv
module qspi_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_enable,
    input logic       sck,
    input logic       mosi,
    input logic [3:0] pcs,
    input logic       busy,
    input logic       done
);
    // R11
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);

    // R6
    pcs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (pcs == 4'hF));

    // R6
    pcs_active_chk: assert property (@(posedge clk) disable iff (rst)
        sck |-> (pcs != 4'hF));

    // R11
    mosi_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));

    // R4
    sck_min_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |=> sck);

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done && cfg_enable && $past(cfg_enable)) |=> done);
endmodule

bind qspi_engine qspi_engine_chk chk_i (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .sck(sck), .mosi(mosi),
    .pcs(pcs), .busy(busy), .done(done)
);

// File: tb/qspi_engine_tb.sv
module qspi_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LOG = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_cmd = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        cfg_enable = 1'b0;
    logic        cfg_wrap = 1'b0;
    logic [4:0]  cfg_start = '0;
    logic [4:0]  cfg_end = '0;
    logic [7:0]  cfg_div = 8'd2;
    logic        miso;
    logic        sck;
    logic        mosi;
    logic [3:0]  pcs;
    logic        busy;
    logic        done;

    int ncheck = 0;
    int nfail  = 0;

    logic [15:0] tx_m  [32];
    logic [15:0] cmd_m [32];

    // Peripheral model: a fixed bit stream, advanced on each falling sck
    int scnt = 0;
    function automatic logic sbit(input int i);
        int v;
        v = (i * 7 + (i >> 2)) % 5;
        return v < 2;
    endfunction
    assign miso = sbit(scnt);

    always @(negedge sck) scnt = scnt + 1;

    // Capture of mosi, pcs and sck period at every rising sck edge
    int   cyc = 0;
    int   last_rise = 0;
    int   capn = 0;
    logic       cap_bit [LOG];
    logic [3:0] cap_sel [LOG];
    int         per_log [LOG];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    always @(posedge sck) begin
        cap_bit[capn % LOG] = mosi;
        cap_sel[capn % LOG] = pcs;
        per_log[capn % LOG] = cyc - last_rise;
        last_rise = cyc;
        capn = capn + 1;
    end

    // Counts cycles where select is idle between words of a running list
    int gap_cnt = 0;
    bit armed = 0;
    always @(negedge clk) begin
        if (!busy) armed = 0;
        else begin
            if (armed && pcs == 4'hF) gap_cnt = gap_cnt + 1;
            if (sck) armed = 1;
        end
    end

    qspi_engine dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg_enable(cfg_enable), .cfg_wrap(cfg_wrap), .cfg_start(cfg_start),
        .cfg_end(cfg_end), .cfg_div(cfg_div), .miso(miso), .sck(sck),
        .mosi(mosi), .pcs(pcs), .busy(busy), .done(done)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        ncheck++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int blen(input logic [15:0] c);
        return (c[8:5] < 4'd7) ? 8 : int'(c[8:5]) + 1;
    endfunction

    function automatic logic [15:0] mk_cmd(input int len, input bit hold, input int sel);
        return {7'd0, 4'(len), hold, 4'(sel)};
    endfunction

    task automatic put(input int idx, input logic [15:0] tx, input logic [15:0] cmd);
        tx_m[idx]  = tx;
        cmd_m[idx] = cmd;
        @(negedge clk);
        wr_en = 1'b1; wr_cmd = 1'b0; wr_addr = 5'(idx); wr_data = tx;
        @(negedge clk);
        wr_cmd = 1'b1; wr_data = cmd;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic test_reset;
        check_eq("R1 sck", 32'(sck), 0);
        check_eq("R1 mosi", 32'(mosi), 0);
        check_eq("R1 pcs", 32'(pcs), 32'hF);
        check_eq("R1 busy", 32'(busy), 0);
        check_eq("R1 done", 32'(done), 0);
    endtask

    // Runs slots first..last once and checks stream, selects, data and timing
    task automatic run_list(input int first, input int last, input int div_n, input int exp_gaps);
        int c0, s0, g0, off, st, mism, selmis, idx, b, pmin, nh;
        logic [15:0] exp;
        cfg_div = 8'(div_n); cfg_start = 5'(first); cfg_end = 5'(last); cfg_wrap = 1'b0;
        c0 = capn; s0 = scnt; g0 = gap_cnt;
        cfg_enable = 1'b1;
        @(negedge clk); @(negedge clk);
        while (!done) @(negedge clk);
        while (busy) @(negedge clk);
        cfg_enable = 1'b0;
        @(negedge clk);
        off = 0; mism = 0; selmis = 0; idx = first;
        for (int e = 0; e < 32; e++) begin
            b = blen(cmd_m[idx]);
            st = off;
            for (int j = b - 1; j >= 0; j--) begin
                if (cap_bit[(c0 + off) % LOG] !== tx_m[idx][j]) mism++;
                if (cap_sel[(c0 + off) % LOG] !== cmd_m[idx][3:0]) selmis++;
                off++;
            end
            exp = '0;
            for (int j = 0; j < b; j++) exp = {exp[14:0], sbit(s0 + st + j)};
            rd_addr = 5'(idx);
            #1;
            check_eq("R3 receive slot", 32'(rd_data), 32'(exp));
            if (idx == last) break;
            idx = (idx + 1) % 32;
        end
        check_eq("R5 total bits", 32'(capn - c0), 32'(off));
        check_eq("R2 mosi bit mismatches", 32'(mism), 0);
        check_eq("R6 select mismatches", 32'(selmis), 0);
        nh = (div_n < 2) ? 2 : div_n;
        pmin = 1000000;
        for (int r = c0 + 1; r < capn; r++)
            if (per_log[r % LOG] < pmin) pmin = per_log[r % LOG];
        check_eq("R4 sck period", 32'(pmin), 32'(2 * nh));
        check_eq("R7 done", 32'(done), 1);
        check_eq("R7 busy", 32'(busy), 0);
        check_eq("R6 idle select gaps", 32'(gap_cnt - g0), 32'(exp_gaps));
    endtask

    task automatic test_basic;
        put(0, 16'h00A5, mk_cmd(7, 0, 2));
        put(1, 16'h0ABC, mk_cmd(11, 0, 9));
        put(2, 16'hC3E1, mk_cmd(15, 0, 14));
        run_list(0, 2, 3, 2);
    endtask

    task automatic test_hold_clamp;
        put(5, 16'h005A, mk_cmd(2, 1, 1));
        put(6, 16'h1234, mk_cmd(9, 1, 7));
        run_list(5, 6, 0, 0);
    endtask

    task automatic test_wrap;
        int c0, total, t, selmis, mism;
        int seq [4];
        seq[0] = 30; seq[1] = 31; seq[2] = 0; seq[3] = 1;
        put(30, 16'h0081, mk_cmd(7, 0, 3));
        put(31, 16'h00C2, mk_cmd(7, 0, 4));
        put(0,  16'h0037, mk_cmd(7, 0, 5));
        put(1,  16'h00E9, mk_cmd(7, 0, 6));
        cfg_div = 8'd2; cfg_start = 5'd30; cfg_end = 5'd1; cfg_wrap = 1'b1;
        c0 = capn;
        cfg_enable = 1'b1;
        @(negedge clk); @(negedge clk);
        while (!done) @(negedge clk);
        while (capn - c0 < 8 * 6) @(negedge clk);
        check_eq("R8 done after first pass", 32'(done), 1);
        check_eq("R8 still running", 32'(busy), 1);
        cfg_enable = 1'b0;
        while (busy) @(negedge clk);
        cfg_wrap = 1'b0;
        total = capn - c0;
        t = total / 8;
        check_eq("R9 whole words only", 32'(total % 8), 0);
        selmis = 0; mism = 0;
        for (int k = 0; k < t; k++) begin
            if (cap_sel[(c0 + k * 8) % LOG] !== cmd_m[seq[k % 4]][3:0]) selmis++;
            for (int j = 0; j < 8; j++)
                if (cap_bit[(c0 + k * 8 + j) % LOG] !== tx_m[seq[k % 4]][7 - j]) mism++;
        end
        check_eq("R10 slot order across 31 to 0", 32'(selmis), 0);
        check_eq("R8 data over repeated passes", 32'(mism), 0);
        check_eq("R8 at least a second pass", 32'(t >= 6), 1);
    endtask

    task automatic test_stop;
        int c0, s0;
        logic [15:0] exp;
        put(8,  16'h0F0F, mk_cmd(11, 0, 2));
        put(9,  16'h0333, mk_cmd(11, 0, 3));
        put(10, 16'h0555, mk_cmd(11, 0, 4));
        cfg_div = 8'd2; cfg_start = 5'd8; cfg_end = 5'd10; cfg_wrap = 1'b0;
        c0 = capn; s0 = scnt;
        cfg_enable = 1'b1;
        @(negedge clk); @(negedge clk);
        while (capn - c0 < 3) @(negedge clk);
        cfg_enable = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        check_eq("R9 bits after stop", 32'(capn - c0), 12);
        check_eq("R9 done stays low", 32'(done), 0);
        exp = '0;
        for (int j = 0; j < 12; j++) exp = {exp[14:0], sbit(s0 + j)};
        rd_addr = 5'd8;
        #1;
        check_eq("R9 finished word stored", 32'(rd_data), 32'(exp));
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        ncheck++;
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_basic();
        test_hold_clamp();
        test_wrap();
        test_stop();
        finish_run();
    end
endmodule